// File: doc/BRIEF.md
# Serial Bit-Slice Router

This block moves single bits from sixteen source shift registers to sixteen destination shift registers over one shared one-bit path. Each source register is parallel-loaded and presents its most significant bit to a selector. The selector is split into two banks of eight, and one address bit picks which bank may drive the path. The bit on the path reaches exactly one destination register, chosen by a destination address held in a transparent latch. A separate inhibit input blocks delivery.

Software or a surrounding controller can steer bits one cycle at a time through the manual inputs. A built-in sequencer can instead perform a full bit-matrix transpose. It scans all sixteen sources for one bit position before the sources shift to the next position, so bit position k of every source ends up gathered in destination register k.

Top module: `bitslice_router`

## Requirements
- R1: A synchronous reset clears every source register, every destination register, the destination latch and the sequencer, so that `out_data`, `bus_bit`, `busy` and `done` all read 0.
- R2: A `load` pulse while idle copies `load_data[i*DATA_W +: DATA_W]` into source register i. `bus_bit` combinationally shows the MSB of the selected source. `src_addr[3]` = 0 selects sources 0–7 and `src_addr[3]` = 1 selects sources 8–15, with `src_addr[2:0]` giving the index within the bank.
- R3: An `advance` pulse while idle, with `load` low, shifts every source register left by one, filling with 0. The next lower bit then becomes the visible MSB.
- R4: While idle with `inhibit` low, the destination register k given by the effective destination address shifts left by one and takes `bus_bit` into its LSB. Register k is `out_data[k*16 +: 16]`. All other destination registers hold their value.
- R5: While idle with `inhibit` high, no destination register changes.
- R6: The effective destination equals `dst_addr` when `dst_strobe` is high. When `dst_strobe` is low, it equals the address present at the last clock edge at which the strobe was high.
- R7: A `start` pulse while idle runs a transpose. Source index 0..15 is the inner loop and bit position is the outer loop. For each bit position b < DATA_W, destination register b ends with source s's bit DATA_W-1-b at position 15-s. Destination registers DATA_W and above keep their contents. Afterwards all source registers read zero and the destination latch holds DATA_W-1.
- R8: `busy` stays high for exactly 16·DATA_W cycles after the start edge. `done` rises in the cycle `busy` falls, stays high until the next start, and clears at that start.
- R9: While `busy`, the `load`, `advance`, `inhibit`, `start`, `src_addr`, `dst_addr` and `dst_strobe` inputs have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Parallel load of all source registers |
| load_data | input | 16·DATA_W | Load image, source i at slice i |
| advance | input | 1 | Shift all source registers by one bit |
| src_addr | input | 4 | Bank select (bit 3) and index within the bank |
| dst_addr | input | 4 | Destination address into the latch |
| dst_strobe | input | 1 | Latch transparent while high |
| inhibit | input | 1 | Blocks delivery to destinations while high |
| start | input | 1 | Begin an automatic transpose |
| bus_bit | output | 1 | Current bit on the shared path |
| out_data | output | 256 | Destination registers, register k at slice k |
| busy | output | 1 | Transpose running |
| done | output | 1 | Transpose finished |

## Verification
The bench builds the router with DATA_W = 8 and keeps the two banks of eight. A transpose therefore finishes in 128 cycles and fills only destination registers 0–7. This leaves registers 8–15 as witnesses that the run does not touch destinations beyond the source width. With the shorter word, the bench can also run two full transposes and step the manual path through both banks, inhibited and latched cases, all within a short run.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int unsigned NBANK = 2;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_t;
endpackage

// File: rtl/bsr_bank_sel.sv
module bsr_bank_sel #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned SEL_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] msbs,
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  output logic             bit_o
);
  assign bit_o = en & msbs[sel];
endmodule

// File: rtl/bsr_dest_dec.sv
module bsr_dest_dec #(
  parameter int unsigned N  = 16,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          strobe,
  input  logic          inhibit,
  output logic [N-1:0]  lines
);
  logic [AW-1:0] held_q;
  logic [AW-1:0] eff;

  assign eff = strobe ? addr : held_q;

  always_ff @(posedge clk) begin
    if (rst)         held_q <= '0;
    else if (strobe) held_q <= addr;
  end

  for (genvar k = 0; k < N; k++) begin : g_line
    assign lines[k] = !inhibit && (eff == AW'(k));
  end
endmodule

// File: rtl/bsr_sequencer.sv
module bsr_sequencer
  import bsr_pkg::*;
#(
  parameter int unsigned NSRC   = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AW     = 4,
  localparam int unsigned BW    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_idx,
  output logic [AW-1:0] dst_idx,
  output logic          bit_step
);
  seq_state_t    state_q;
  logic [AW-1:0] src_q;
  logic [BW-1:0] bit_q;
  logic          done_q;
  logic          last_src;

  assign last_src = (src_q == AW'(NSRC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      src_q   <= '0;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start) begin
          state_q <= SEQ_RUN;
          src_q   <= '0;
          bit_q   <= '0;
          done_q  <= 1'b0;
        end
        default: begin
          if (last_src) begin
            src_q <= '0;
            if (bit_q == BW'(DATA_W - 1)) begin
              state_q <= SEQ_IDLE;
              done_q  <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end else begin
            src_q <= src_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy     = (state_q == SEQ_RUN);
  assign done     = done_q;
  assign src_idx  = src_q;
  assign dst_idx  = AW'(bit_q);
  assign bit_step = busy && last_src;
endmodule

// File: rtl/bitslice_router.sv
module bitslice_router
  import bsr_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned OUT_W      = 16,
  parameter int unsigned BANK_DEPTH = 8,
  localparam int unsigned NSRC  = NBANK * BANK_DEPTH,
  localparam int unsigned SEL_W = $clog2(BANK_DEPTH),
  localparam int unsigned AW    = SEL_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [NSRC*DATA_W-1:0] load_data,
  input  logic                   advance,
  input  logic [AW-1:0]          src_addr,
  input  logic [AW-1:0]          dst_addr,
  input  logic                   dst_strobe,
  input  logic                   inhibit,
  input  logic                   start,
  output logic                   bus_bit,
  output logic [NSRC*OUT_W-1:0]  out_data,
  output logic                   busy,
  output logic                   done
);
  logic [DATA_W-1:0] in_q  [NSRC];
  logic [OUT_W-1:0]  out_q [NSRC];
  logic [NSRC-1:0]   msbs;
  logic [NBANK-1:0]  bank_bits;
  logic [NSRC-1:0]   dec_lines;
  logic [AW-1:0]     seq_src, seq_dst, src_sel, dst_sel;
  logic              seq_step, shift_src;

  bsr_sequencer #(.NSRC(NSRC), .DATA_W(DATA_W), .AW(AW)) seq_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .src_idx(seq_src), .dst_idx(seq_dst), .bit_step(seq_step)
  );

  assign src_sel   = busy ? seq_src : src_addr;
  assign dst_sel   = busy ? seq_dst : dst_addr;
  assign shift_src = busy ? seq_step : (advance && !load);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bsr_bank_sel #(.DEPTH(BANK_DEPTH)) sel_i (
      .msbs (msbs[b*BANK_DEPTH +: BANK_DEPTH]),
      .sel  (src_sel[SEL_W-1:0]),
      .en   (src_sel[AW-1] == 1'(b)),
      .bit_o(bank_bits[b])
    );
  end
  assign bus_bit = |bank_bits;

  bsr_dest_dec #(.N(NSRC), .AW(AW)) dec_i (
    .clk(clk), .rst(rst), .addr(dst_sel),
    .strobe(busy | dst_strobe), .inhibit(!busy && inhibit),
    .lines(dec_lines)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_reg
    assign msbs[i] = in_q[i][DATA_W-1];

    always_ff @(posedge clk) begin
      if (rst)                in_q[i] <= '0;
      else if (!busy && load) in_q[i] <= load_data[i*DATA_W +: DATA_W];
      else if (shift_src)     in_q[i] <= in_q[i] << 1;
    end

    always_ff @(posedge clk) begin
      if (rst)               out_q[i] <= '0;
      else if (dec_lines[i]) out_q[i] <= {out_q[i][OUT_W-2:0], bus_bit};
    end

    assign out_data[i*OUT_W +: OUT_W] = out_q[i];
  end
endmodule

// File: rtl/bsr_router_chk.sv
module bsr_router_chk #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned OUT_W      = 16,
  parameter int unsigned BANK_DEPTH = 8,
  localparam int unsigned NSRC    = 2 * BANK_DEPTH,
  localparam int unsigned RUN_LEN = NSRC * DATA_W
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  inhibit,
  input logic                  busy,
  input logic                  done,
  input logic [NSRC*OUT_W-1:0] out_data,
  input logic [NSRC-1:0]       dec_lines
);
  int unsigned run_cnt;

  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (out_data == '0 && !busy && !done));

  // R5
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inhibit && !busy) |=> $stable(out_data));

  // R5
  inhibit_lines_chk: assert property (@(posedge clk) disable iff (rst)
    (inhibit && !busy) |-> (dec_lines == '0));

  // R7
  run_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(dec_lines) == 1));

  // R8
  run_length_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_cnt == RUN_LEN && done));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind bitslice_router bsr_router_chk #(
  .DATA_W(DATA_W), .OUT_W(OUT_W), .BANK_DEPTH(BANK_DEPTH)
) chk_i (
  .clk(clk), .rst(rst), .inhibit(inhibit), .busy(busy), .done(done),
  .out_data(out_data), .dec_lines(dec_lines)
);

// File: tb/bitslice_router_tb_top.sv
module bitslice_router_tb_top;
  localparam int DW = 8;
  localparam int NS = 16;
  localparam int OW = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic              load, advance, dst_strobe, inhibit, start;
  logic [NS*DW-1:0]  load_data;
  logic [3:0]        src_addr, dst_addr;
  logic              bus_bit, busy, done;
  logic [NS*OW-1:0]  out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [DW-1:0] ld   [NS];
  logic [DW-1:0] m_in [NS];
  logic [OW-1:0] m_out[NS];
  logic [3:0]    m_dq;

  always #4 clk = ~clk;

  bitslice_router #(.DATA_W(DW), .OUT_W(OW), .BANK_DEPTH(8)) dut_i (
    .clk(clk), .rst(rst), .load(load), .load_data(load_data),
    .advance(advance), .src_addr(src_addr), .dst_addr(dst_addr),
    .dst_strobe(dst_strobe), .inhibit(inhibit), .start(start),
    .bus_bit(bus_bit), .out_data(out_data), .busy(busy), .done(done)
  );

  // vector: {src[3:0], dst[3:0], strobe, inhibit, advance}
  localparam logic [10:0] VEC [12] = '{
    {4'd3,  4'd5,  1'b1, 1'b0, 1'b0},
    {4'd11, 4'd9,  1'b0, 1'b0, 1'b0},
    {4'd0,  4'd2,  1'b1, 1'b1, 1'b0},
    {4'd15, 4'd0,  1'b0, 1'b0, 1'b0},
    {4'd7,  4'd15, 1'b1, 1'b0, 1'b1},
    {4'd7,  4'd15, 1'b1, 1'b0, 1'b0},
    {4'd8,  4'd14, 1'b1, 1'b1, 1'b1},
    {4'd8,  4'd14, 1'b1, 1'b0, 1'b0},
    {4'd12, 4'd1,  1'b1, 1'b0, 1'b0},
    {4'd12, 4'd3,  1'b0, 1'b0, 1'b0},
    {4'd4,  4'd0,  1'b1, 1'b0, 1'b1},
    {4'd13, 4'd0,  1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [NS*OW-1:0] act, input logic [NS*OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NS*OW-1:0] pack_out();
    logic [NS*OW-1:0] v;
    for (int k = 0; k < NS; k++) v[k*OW +: OW] = m_out[k];
    return v;
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1'b1;
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    int cnt;
    logic [3:0] eff;
    logic exp_bus;
    rst = 1'b1; load = 0; advance = 0; dst_strobe = 0; inhibit = 1'b1;
    start = 0; src_addr = 0; dst_addr = 0; load_data = '0;
    for (int i = 0; i < NS; i++) ld[i] = DW'((i * 37 + 11) ^ (i << 3) ^ 8'h96);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 out", out_data, '0);
    check("R1 bus/busy/done", {bus_bit, busy, done}, '0);

    // R2: parallel load
    for (int i = 0; i < NS; i++) begin
      load_data[i*DW +: DW] = ld[i];
      m_in[i] = ld[i];
      m_out[i] = '0;
    end
    m_dq = '0;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;

    // vector table: R2/R3 on the bus, R4/R5/R6 on the destinations
    for (int v = 0; v < 12; v++) begin
      src_addr = VEC[v][10:7]; dst_addr = VEC[v][6:3];
      dst_strobe = VEC[v][2]; inhibit = VEC[v][1]; advance = VEC[v][0];
      #1;
      exp_bus = m_in[src_addr][DW-1];
      check("R2/R3 bus", NS*OW'(bus_bit), NS*OW'(exp_bus));
      @(posedge clk);
      eff = dst_strobe ? dst_addr : m_dq;
      if (dst_strobe) m_dq = dst_addr;
      if (!inhibit) m_out[eff] = {m_out[eff][OW-2:0], exp_bus};
      if (advance) for (int i = 0; i < NS; i++) m_in[i] = m_in[i] << 1;
      #2;
      if (inhibit)         check("R5 out", out_data, pack_out());
      else if (!dst_strobe) check("R6 out", out_data, pack_out());
      else                 check("R4 out", out_data, pack_out());
      @(negedge clk);
      inhibit = 1'b1; advance = 1'b0;
    end

    // R7: reload and transpose; R9: interference during the run
    for (int i = 0; i < NS; i++) begin
      load_data[i*DW +: DW] = ld[i];
      m_in[i] = ld[i];
    end
    load = 1'b1;
    @(negedge clk);
    load = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (busy) begin
      cnt++;
      if (cnt == 20) begin
        load = 1'b1; load_data = ~load_data; advance = 1'b1;
        inhibit = 1'b0; start = 1'b1; dst_strobe = 1'b1; dst_addr = 4'd12;
        src_addr = 4'd9;
      end
      if (cnt == 25) begin
        load = 1'b0; advance = 1'b0; inhibit = 1'b1; start = 1'b0; dst_strobe = 1'b0;
      end
      @(negedge clk);
    end
    for (int b = 0; b < DW; b++)
      for (int s = 0; s < NS; s++)
        m_out[b] = {m_out[b][OW-2:0], ld[s][DW-1-b]};
    check("R8 busy length", NS*OW'(cnt), NS*OW'(NS*DW));
    check("R8 done", NS*OW'(done), NS*OW'(1));
    check("R7/R9 out", out_data, pack_out());
    src_addr = 4'd3; #1;
    check("R7 sources empty", NS*OW'(bus_bit), '0);
    src_addr = 4'd13; #1;
    check("R7 sources empty hi", NS*OW'(bus_bit), '0);

    repeat (5) @(negedge clk);
    check("R8 done held", NS*OW'(done), NS*OW'(1));

    // R8: second run clears done, sources are zero so registers 0..DW-1 clear
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 done clears", NS*OW'({busy, done}), NS*OW'(2'b10));
    while (busy) @(negedge clk);
    for (int b = 0; b < DW; b++) m_out[b] = '0;
    check("R7 second run", out_data, pack_out());
    check("R8 done again", NS*OW'(done), NS*OW'(1));

    // R6: latch left at DW-1 by the run; strobe low delivers there
    src_addr = 4'd0; inhibit = 1'b0; dst_strobe = 1'b0;
    @(posedge clk); #2;
    m_out[DW-1] = {m_out[DW-1][OW-2:0], 1'b0};
    check("R6 latch after run", out_data, pack_out());
    @(negedge clk);
    inhibit = 1'b1;

    // R1: reset after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 out after reset", out_data, '0);
    check("R1 flags after reset", NS*OW'({busy, done}), '0);
    finish_run();
  end
endmodule